// File: doc/BRIEF.md
# Block-Partitioned Carry-Select Adder

A purely combinational two-operand binary adder with carry-in and carry-out. The operand width is cut into equal blocks. The least significant block is a plain ripple-carry adder that is fed by the external carry-in. Each higher block holds two ripple-carry adders that run side by side. One assumes the carry entering the block is 0 and the other assumes it is 1. Both results are ready while the real carry is still on its way from below.

The real carry into each upper block selects one of its two precomputed results, both the sum slice and the block carry-out, through 2:1 multiplexers. The selected carry-out then drives the selector of the next block up. The carry that passes between blocks therefore crosses only one multiplexer per block and never re-enters an adder cell. The design holds no state and uses no clock, so every output is a function of the present inputs only. With the defaults the adder is 12 bits wide, in three 4-bit blocks.

Top module: `csel_adder_top`

## Requirements
- R1: `sum_o` equals the low 12 bits of `a_i + b_i + cin_i`, taken as unsigned integers, for every input combination.
- R2: `cout_o` equals bit 12 of `a_i + b_i + cin_i`.
- R3: Sum bits 3:0 equal the low 4 bits of `a_i[3:0] + b_i[3:0] + cin_i`, independent of bits 11:4 of the operands.
- R4: The carry handed into block k (bit position 4k, for k = 1 and 2) equals bit 4k of `a_i[4k-1:0] + b_i[4k-1:0] + cin_i`. The carry-out of the top block is `cout_o`.
- R5: A carry born in bit 0 travels the full width: 0x001 + 0xFFF gives sum 0x000 with `cout_o` = 1, and 0x000 + 0xFFF with `cin_i` = 1 gives the same result.
- R6: With both operands at 0xFFF and `cin_i` = 1, the result is sum 0xFFF with `cout_o` = 1.
- R7: With both operands zero and `cin_i` = 0, the sum is 0x000 and `cout_o` = 0.
- R8: With both operands zero, `cin_i` = 1 gives sum 0x001 and `cout_o` = 0.
- R9: The outputs hold no state. Applying the same inputs again after unrelated traffic gives identical outputs.
- R10: A carry that stops at a block edge lands correctly: 0x00F + 0x001 = 0x010, 0x0F0 + 0x010 = 0x100, and 0x7FF + 0x001 = 0x800, each with `cout_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 12 | First operand, unsigned |
| b_i | input | 12 | Second operand, unsigned |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 12 | Sum, modulo 2^12 |
| cout_o | output | 1 | Carry out of bit 11 |

## Verification
The bench builds the adder only with its default parameters, three blocks of four bits. This is small enough that the hand-chosen table can place a carry that dies exactly at each block edge, and another that crosses every block selector. The random phase adds several thousand operand pairs against an integer reference. It checks each sum slice separately, so a wrong choice in any single block shows up on its own. The bound checker compares the internal carry chain at each block edge against a partial-width sum, so a wrong selector polarity is caught at the block where it occurs.

// File: rtl/csel_pkg.sv
package csel_pkg;
  localparam int unsigned DEF_BLK_W   = 4;
  localparam int unsigned DEF_NUM_BLK = 3;
endpackage

// File: rtl/csel_ripple.sv
module csel_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W:0] c;
  assign c[0] = c_i;

  for (genvar i = 0; i < W; i++) begin : g_fa
    logic p;
    assign p      = a_i[i] ^ b_i[i];
    assign s_o[i] = p ^ c[i];
    assign c[i+1] = (a_i[i] & b_i[i]) | (p & c[i]);
  end

  assign c_o = c[W];
endmodule

// File: rtl/csel_select_blk.sv
module csel_select_blk #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sel_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);
  logic [W-1:0] s_z, s_o1;
  logic         c_z, c_o1;

  // speculative pair: carry-in tied to 0 and to 1
  csel_ripple #(.W(W)) u_rc_z (.a_i(a_i), .b_i(b_i), .c_i(1'b0), .s_o(s_z),  .c_o(c_z));
  csel_ripple #(.W(W)) u_rc_o (.a_i(a_i), .b_i(b_i), .c_i(1'b1), .s_o(s_o1), .c_o(c_o1));

  assign s_o = sel_i ? s_o1 : s_z;
  assign c_o = sel_i ? c_o1 : c_z;
endmodule

// File: rtl/csel_adder_top.sv
module csel_adder_top
  import csel_pkg::*;
#(
  parameter int unsigned BLK_W   = DEF_BLK_W,
  parameter int unsigned NUM_BLK = DEF_NUM_BLK,
  localparam int unsigned W      = BLK_W * NUM_BLK
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  // blk_carry[k] enters block k; blk_carry[NUM_BLK] leaves the top block
  logic [NUM_BLK:0] blk_carry;
  assign blk_carry[0] = cin_i;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    localparam int unsigned LO = k * BLK_W;
    if (k == 0) begin : g_base
      csel_ripple #(.W(BLK_W)) u_rc (
        .a_i (a_i[LO +: BLK_W]),
        .b_i (b_i[LO +: BLK_W]),
        .c_i (blk_carry[k]),
        .s_o (sum_o[LO +: BLK_W]),
        .c_o (blk_carry[k+1])
      );
    end else begin : g_sel
      csel_select_blk #(.W(BLK_W)) u_sb (
        .a_i   (a_i[LO +: BLK_W]),
        .b_i   (b_i[LO +: BLK_W]),
        .sel_i (blk_carry[k]),
        .s_o   (sum_o[LO +: BLK_W]),
        .c_o   (blk_carry[k+1])
      );
    end
  end

  assign cout_o = blk_carry[NUM_BLK];
endmodule

// File: rtl/csel_adder_chk.sv
module csel_adder_chk #(
  parameter int unsigned BLK_W   = 4,
  parameter int unsigned NUM_BLK = 3,
  localparam int unsigned W      = BLK_W * NUM_BLK
) (
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     b_i,
  input logic             cin_i,
  input logic [W-1:0]     sum_o,
  input logic             cout_o,
  input logic [NUM_BLK:0] blk_carry
);
  logic [W:0]       full;
  logic [BLK_W:0]   low;

  always_comb begin
    full = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    low  = {1'b0, a_i[BLK_W-1:0]} + {1'b0, b_i[BLK_W-1:0]} + {{BLK_W{1'b0}}, cin_i};
    p_sum_r1:  assert (sum_o == full[W-1:0]);
    p_cout_r2: assert (cout_o == full[W]);
    p_low_r3:  assert (sum_o[BLK_W-1:0] == low[BLK_W-1:0]);
  end

  for (genvar k = 1; k <= NUM_BLK; k++) begin : g_edge
    localparam int unsigned LW = k * BLK_W;
    logic [LW:0] part;
    always_comb begin
      part = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, cin_i};
      p_edge_carry_r4: assert (blk_carry[k] == part[LW]);
    end
  end
endmodule

bind csel_adder_top csel_adder_chk #(.BLK_W(BLK_W), .NUM_BLK(NUM_BLK)) u_chk (
  .a_i       (a_i),
  .b_i       (b_i),
  .cin_i     (cin_i),
  .sum_o     (sum_o),
  .cout_o    (cout_o),
  .blk_carry (blk_carry)
);

// File: tb/sim_csel_adder_top.sv
module sim_csel_adder_top;
  localparam int unsigned W      = 12;
  localparam int unsigned NV     = 10;
  localparam int unsigned NRAND  = 4000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] a, b, sum;
  logic         cin, cout;
  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  csel_adder_top u0 (.a_i(a), .b_i(b), .cin_i(cin), .sum_o(sum), .cout_o(cout));

  // {a, b, cin, exp_sum, exp_cout}
  localparam logic [37:0] VEC [NV] = '{
    {12'h000, 12'h000, 1'b0, 12'h000, 1'b0},
    {12'h000, 12'h000, 1'b1, 12'h001, 1'b0},
    {12'h001, 12'hFFF, 1'b0, 12'h000, 1'b1},
    {12'hFFF, 12'hFFF, 1'b1, 12'hFFF, 1'b1},
    {12'h00F, 12'h001, 1'b0, 12'h010, 1'b0},
    {12'h0F0, 12'h010, 1'b0, 12'h100, 1'b0},
    {12'h7FF, 12'h001, 1'b0, 12'h800, 1'b0},
    {12'h123, 12'h456, 1'b1, 12'h57A, 1'b0},
    {12'h800, 12'h800, 1'b0, 12'h000, 1'b1},
    {12'h000, 12'hFFF, 1'b1, 12'h000, 1'b1}
  };
  string tags [NV] = '{"R7", "R8", "R5", "R6", "R10", "R10", "R10", "R1", "R2", "R5"};

  task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
    @(posedge clk);
    a = av; b = bv; cin = cv;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h", tag, a, b, cin, act, exp);
    end
  endtask

  initial begin
    logic [W:0] ref_v;
    logic [W:0] keep;
    a = '0; b = '0; cin = 1'b0;
    repeat (2) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][37:26], VEC[i][25:14], VEC[i][13]);
      check(tags[i], {cout, sum}, {VEC[i][0], VEC[i][12:1]});
    end

    for (int n = 0; n < NRAND; n++) begin
      logic [W-1:0] ra, rb;
      logic         rc;
      ra = W'($urandom);
      rb = W'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc);
      ref_v = {1'b0, ra} + {1'b0, rb} + {{W{1'b0}}, rc};
      check("R1", {1'b0, sum}, {1'b0, ref_v[W-1:0]});
      check("R2", {{W{1'b0}}, cout}, {{W{1'b0}}, ref_v[W]});
      // R3: low block from its own slice only
      check("R3", {9'd0, sum[3:0]}, {9'd0, 4'(ra[3:0] + rb[3:0] + 4'(rc))});
      // R4: each upper block slice, selected by the carry from below
      check("R4", {5'd0, sum[11:4]}, {5'd0, ref_v[11:4]});
    end

    // R3: upper operand bits must not disturb the low block
    apply(12'hFF5, 12'h0A3, 1'b1);
    check("R3", {9'd0, sum[3:0]}, {9'd0, 4'h9});

    // R9: repeat a vector after other traffic
    apply(12'h5A5, 12'h3C3, 1'b0);
    keep = {cout, sum};
    apply(12'hFFF, 12'h001, 1'b1);
    apply(12'h5A5, 12'h3C3, 1'b0);
    check("R9", {cout, sum}, keep);
    check("R9", {cout, sum}, {1'b0, 12'h968});

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule